// File: doc/BRIEF.md
# Ingress Tunnel Header Rewriter

This block prepares a packet for routing inside the system. For every packet it takes a lookup record and the first 16 bytes of the frame, given as four 32-bit words. It returns a new 16-byte VLAN-tagged Ethernet header and a three-word descriptor for the queue manager. The block's own MAC address is written once through a configuration port and held in a register. The new source address is that MAC. The new destination address keeps the first five bytes of that MAC and takes its last byte from the lookup record. The VLAN tag also comes from the lookup record.

The descriptor carries the buffer handle, the egress port, the queue identifier and the stats index. It also carries the total frame length, which is the IP packet length plus the 18 bytes of a tagged Ethernet header. The header input and the lookup record are consumed together, in one cycle. The results sit in one output register that honours backpressure. When the consumer keeps output ready high, the block takes one packet per cycle.

Top module: `ingress_hdr_rewriter`

## Requirements
- R1: After reset, out_valid is 0. The held own MAC is all zeros until the first configuration write.
- R2: Output header bytes 6..11 equal the own MAC, with MAC byte 0 in header byte 6. Byte 0 of the header is out_hdr[127:120]. The MAC used is the value written by the last cfg_mac_wr pulse before the packet was accepted. cfg_mac_val[47:40] is MAC byte 0.
- R3: Output header bytes 0..4 equal own MAC bytes 0..4. Header byte 5 equals the lookup destination byte lkp_rec[39:32].
- R4: Output header bytes 12..13 are 0x81, 0x00. Bytes 14..15 are the lookup VLAN lkp_rec[31:16]. The contents of hdr_data have no effect on any output.
- R5: out_desc[31:16] = lkp_rec[95:80] (the IP packet length) + 18, taken modulo 2^16.
- R6: The descriptor holds the following fields, and both reserved nibbles are zero:
  - out_desc[95:64]: the buffer handle, lkp_rec[127:96]
  - out_desc[63:60]: reserved, zero
  - out_desc[59:56]: the port, lkp_rec[63:60]
  - out_desc[55:52]: reserved, zero
  - out_desc[51:32]: the queue id, lkp_rec[59:40]
  - out_desc[15:0]: the stats index, lkp_rec[15:0]
- R7: A packet is consumed only in a cycle where both hdr_valid and lkp_valid are high and the output slot is free. hdr_ready requires lkp_valid, and lkp_ready requires hdr_valid, so neither input is ever consumed alone.
- R8: While out_valid is 1 and out_ready is 0, out_hdr and out_desc hold steady and both input readies are 0.
- R9: A packet accepted at a clock edge appears at the outputs after that edge. With out_ready held at 1, a new packet is accepted on every cycle.
- R10: Take own MAC 01:02:03:04:0a:0b, destination byte 0x02 and VLAN 0x0002. The input header 01020304 05060708 090a0b0c 81000aaa then becomes 01020304 0a020102 03040a0b 81000002.
- R11: The header-length byte lkp_rec[79:72] and the spare byte lkp_rec[71:64] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mac_wr | input | 1 | Load strobe for the own MAC |
| cfg_mac_val | input | 48 | Own MAC value, byte 0 in [47:40] |
| hdr_valid | input | 1 | Header words present |
| hdr_ready | output | 1 | Header words taken this cycle when valid |
| hdr_data | input | 128 | First 16 frame bytes, word 0 in [127:96] |
| lkp_valid | input | 1 | Lookup record present |
| lkp_ready | output | 1 | Lookup record taken this cycle when valid |
| lkp_rec | input | 128 | Lookup record, fields as in R2..R6 and R11 |
| out_valid | output | 1 | Rewritten header and descriptor present |
| out_ready | input | 1 | Consumer takes the output |
| out_hdr | output | 128 | Rewritten header, byte 0 in [127:120] |
| out_desc | output | 96 | Queue descriptor |

## Verification
The bench sweeps every value of the destination byte under three own-MAC values, with stall lengths that rotate from packet to packet. If the last MAC byte is put in the wrong place, or if the wrong MAC byte is kept, the expected header shows the error at once. The IP length is pushed to 0xFFED, 0xFFEE and 0xFFFF. A design that widened the sum, or added 14 in place of 18, would fail there. The input header bytes and the unused record bytes are scrambled so that any leak of them into the output shows. The stimulus also includes one-sided valids, long stalls, a streaming burst and a MAC reload. These catch a block that takes one input without the other, changes its output while stalled, loses throughput, or keeps using an old MAC.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int MAC_W     = 48;
  localparam int HDR_BYTES = 16;
  localparam int HDR_W     = HDR_BYTES * 8;

  typedef struct packed {
    logic [31:0] handle;
    logic [15:0] ip_len;
    logic [7:0]  hdr_len;
    logic [7:0]  spare;
    logic [3:0]  port;
    logic [19:0] qid;
    logic [7:0]  dst_lsb;
    logic [15:0] vlan;
    logic [15:0] stats;
  } lkp_rec_t;

  typedef struct packed {
    logic [31:0] handle;
    logic [3:0]  rsv_a;
    logic [3:0]  port;
    logic [3:0]  rsv_b;
    logic [19:0] qid;
    logic [15:0] frame_len;
    logic [15:0] stats;
  } qdesc_t;

  localparam int REC_W  = $bits(lkp_rec_t);
  localparam int DESC_W = $bits(qdesc_t);

  // total tagged frame length, wraps at 16 bits
  function automatic logic [15:0] frame_len_of(input logic [15:0] ip_len,
                                               input logic [15:0] tag_len);
    return ip_len + tag_len;
  endfunction

  // byte idx of a MAC, byte 0 being the most significant
  function automatic logic [7:0] mac_byte(input logic [MAC_W-1:0] mac,
                                          input int idx);
    return mac[MAC_W-1-8*idx -: 8];
  endfunction
endpackage

// File: rtl/hf_mac_reg.sv
module hf_mac_reg
  import hf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [MAC_W-1:0] val,
  output logic [MAC_W-1:0] mac
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mac <= '0;
    else if (wr) mac <= val;
  end

  // R2: a write is visible on the next cycle
  p_mac_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> mac == $past(val));
endmodule

// File: rtl/hf_hdr_build.sv
module hf_hdr_build
  import hf_pkg::*;
#(
  parameter logic [15:0] TPID     = 16'h8100,
  parameter int          DST_KEEP = 5
) (
  input  logic [MAC_W-1:0] mac,
  input  logic [7:0]       dst_lsb,
  input  logic [15:0]      vlan,
  output logic [HDR_W-1:0] hdr
);
  localparam int MAC_BYTES = MAC_W / 8;
  localparam int SRC_BASE  = MAC_BYTES;
  localparam int TAG_BASE  = 2 * MAC_BYTES;

  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
    if (i < DST_KEEP) begin : g_dst_keep
      assign hdr[HDR_W-1-8*i -: 8] = mac_byte(mac, i);
    end else if (i < SRC_BASE) begin : g_dst_new
      assign hdr[HDR_W-1-8*i -: 8] = dst_lsb;
    end else if (i < TAG_BASE) begin : g_src
      assign hdr[HDR_W-1-8*i -: 8] = mac_byte(mac, i - SRC_BASE);
    end else if (i == TAG_BASE) begin : g_tpid_hi
      assign hdr[HDR_W-1-8*i -: 8] = TPID[15:8];
    end else if (i == TAG_BASE + 1) begin : g_tpid_lo
      assign hdr[HDR_W-1-8*i -: 8] = TPID[7:0];
    end else if (i == TAG_BASE + 2) begin : g_vlan_hi
      assign hdr[HDR_W-1-8*i -: 8] = vlan[15:8];
    end else begin : g_vlan_lo
      assign hdr[HDR_W-1-8*i -: 8] = vlan[7:0];
    end
  end
endmodule

// File: rtl/hf_desc_pack.sv
module hf_desc_pack
  import hf_pkg::*;
#(
  parameter logic [15:0] TAG_HDR_LEN = 16'd18
) (
  input  lkp_rec_t rec,
  output qdesc_t   desc
);
  logic [15:0] unused_rec_bytes;
  assign unused_rec_bytes = {rec.hdr_len, rec.spare};

  always_comb begin
    desc           = '0;
    desc.handle    = rec.handle;
    desc.port      = rec.port;
    desc.qid       = rec.qid;
    desc.frame_len = frame_len_of(rec.ip_len, TAG_HDR_LEN);
    desc.stats     = rec.stats;
  end
endmodule

// File: rtl/hf_out_stage.sv
module hf_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         slot_free
);
  assign slot_free = !valid || take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      if (load)      valid <= 1'b1;
      else if (take) valid <= 1'b0;
      if (load) dout <= din;
    end
  end

  // R8: a stalled output holds its content
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(dout)));
  // R9: an accepted packet is shown on the next cycle
  p_load_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);
endmodule

// File: rtl/ingress_hdr_rewriter.sv
module ingress_hdr_rewriter
  import hf_pkg::*;
#(
  parameter logic [15:0] TPID        = 16'h8100,
  parameter logic [15:0] TAG_HDR_LEN = 16'd18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mac_wr,
  input  logic [MAC_W-1:0]  cfg_mac_val,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [HDR_W-1:0]  hdr_data,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [REC_W-1:0]  lkp_rec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HDR_W-1:0]  out_hdr,
  output logic [DESC_W-1:0] out_desc
);
  localparam int STAGE_W = HDR_W + DESC_W;

  logic [MAC_W-1:0] own_mac;
  lkp_rec_t         rec;
  qdesc_t           desc_new;
  logic [HDR_W-1:0] hdr_new;
  logic             slot_free;
  logic             accept_fire;
  logic             out_take;
  logic             out_stall;
  logic [HDR_W-1:0] unused_hdr_data;

  assign rec             = lkp_rec_t'(lkp_rec);
  assign unused_hdr_data = hdr_data;

  hf_mac_reg u_mac (
    .clk(clk), .rst_n(rst_n), .wr(cfg_mac_wr), .val(cfg_mac_val), .mac(own_mac)
  );

  hf_hdr_build #(.TPID(TPID)) u_build (
    .mac(own_mac), .dst_lsb(rec.dst_lsb), .vlan(rec.vlan), .hdr(hdr_new)
  );

  hf_desc_pack #(.TAG_HDR_LEN(TAG_HDR_LEN)) u_desc (
    .rec(rec), .desc(desc_new)
  );

  // joint acceptance of header and lookup record
  assign hdr_ready   = slot_free && lkp_valid;
  assign lkp_ready   = slot_free && hdr_valid;
  assign accept_fire = hdr_valid && lkp_valid && slot_free;
  assign out_take    = out_valid && out_ready;
  assign out_stall   = out_valid && !out_ready;

  hf_out_stage #(.W(STAGE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept_fire),
    .din({hdr_new, desc_new}), .take(out_take),
    .valid(out_valid), .dout({out_hdr, out_desc}), .slot_free(slot_free)
  );

  // R7: the two inputs are consumed in the same cycle
  p_joint_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |-> (lkp_valid && lkp_ready));
  p_joint_lkp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_ready) |-> (hdr_valid && hdr_ready));
  // R8: no intake while the output is stalled
  p_no_take_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |-> (!hdr_ready && !lkp_ready));
  // R3: destination prefix matches the source prefix
  p_dst_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hdr[127:88] == out_hdr[79:40]));
  // R4: tag protocol identifier in bytes 12..13
  p_tpid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hdr[31:16] == TPID));
  // R6: reserved descriptor nibbles stay zero
  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_desc[63:60] == 4'h0 && out_desc[55:52] == 4'h0));
  // R1: nothing is presented in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/ingress_hdr_rewriter_test.sv
module ingress_hdr_rewriter_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_mac_wr = 1'b0;
  logic [47:0]  cfg_mac_val = '0;
  logic         hdr_valid = 1'b0;
  logic         hdr_ready;
  logic [127:0] hdr_data = '0;
  logic         lkp_valid = 1'b0;
  logic         lkp_ready;
  logic [127:0] lkp_rec = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_hdr;
  logic [95:0]  out_desc;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;
  logic [31:0] seed = 32'h1357_9bdf;

  always #10 clk = ~clk;

  ingress_hdr_rewriter uut (
    .clk(clk), .rst_n(rst_n), .cfg_mac_wr(cfg_mac_wr), .cfg_mac_val(cfg_mac_val),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_rec(lkp_rec),
    .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr), .out_desc(out_desc)
  );

  function automatic logic [31:0] next_rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [127:0] want_hdr(input logic [47:0] m, input logic [7:0] d,
                                            input logic [15:0] v);
    return {m[47:8], d, m, 16'h8100, v};
  endfunction

  function automatic logic [95:0] want_desc(input logic [127:0] r);
    logic [15:0] flen;
    flen = r[95:80] + 16'd18;
    return {r[127:96], 4'h0, r[63:60], 4'h0, r[59:40], flen, r[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_mac(input logic [47:0] m);
    @(negedge clk);
    cfg_mac_wr = 1'b1;
    cfg_mac_val = m;
    @(negedge clk);
    cfg_mac_wr = 1'b0;
  endtask

  task automatic run_pkt(input logic [127:0] hin, input logic [127:0] rec,
                         input int stall, input logic [47:0] mac);
    logic [127:0] eh;
    logic [95:0]  ed;
    eh = want_hdr(mac, rec[39:32], rec[31:16]);
    ed = want_desc(rec);
    @(negedge clk);
    hdr_data = hin;
    lkp_rec = rec;
    hdr_valid = 1'b1;
    lkp_valid = 1'b1;
    out_ready = 1'b0;
    #1;
    chk(hdr_ready && lkp_ready, "R7 ready with both valid", {hdr_ready, lkp_ready}, 2'b11);
    @(negedge clk);
    hdr_valid = 1'b0;
    lkp_valid = 1'b0;
    chk(out_valid, "R9 output after accept", out_valid, 1);
    chk(out_hdr == eh, "R2 R3 R4 R11 header", out_hdr, eh);
    chk(out_desc == ed, "R5 R6 R11 descriptor", out_desc, ed);
    for (int k = 0; k < stall; k++) begin
      hdr_valid = 1'b1;
      lkp_valid = 1'b1;
      hdr_data = ~hin;
      lkp_rec = ~rec;
      #1;
      chk(!hdr_ready && !lkp_ready, "R8 no intake while stalled", {hdr_ready, lkp_ready}, 0);
      @(negedge clk);
      chk(out_valid && out_hdr == eh && out_desc == ed, "R8 held output",
          {out_hdr[63:0], out_desc[63:0]}, {eh[63:0], ed[63:0]});
    end
    hdr_valid = 1'b0;
    lkp_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R9 drained", out_valid, 0);
    out_ready = 1'b0;
  endtask

  function automatic logic [127:0] make_rec(input logic [31:0] a, input logic [31:0] b,
                                            input logic [7:0] d, input logic [15:0] ip_len);
    return {a, ip_len, b[7:0], b[15:8], b[19:16], b[31:12], d, a[15:0], b[31:16]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] macs [3];
    logic [127:0] rec;
    logic [15:0] lens [5];
    macs[0] = 48'h0102_0304_0a0b;
    macs[1] = 48'hfedc_ba98_7654;
    macs[2] = 48'h00ff_00ff_00ff;
    lens[0] = 16'h0000;
    lens[1] = 16'hffed;
    lens[2] = 16'hffee;
    lens[3] = 16'hffff;
    lens[4] = 16'h0014;

    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !hdr_ready && !lkp_ready, "R1 idle after reset",
        {out_valid, hdr_ready, lkp_ready}, 0);

    // R1: zero MAC before any configuration write
    run_pkt(128'h1111_2222_3333_4444_5555_6666_7777_8888,
            make_rec(32'hcafe_f00d, 32'h1234_5678, 8'h5a, 16'd100), 0, 48'h0);

    // R10: worked example
    load_mac(48'h0102_0304_0a0b);
    @(negedge clk);
    lkp_rec = {32'h0000_0042, 16'd56, 8'd18, 8'h00, 4'h3, 20'h0_0007, 8'h02, 16'h0002, 16'h0009};
    hdr_data = 128'h01020304_05060708_090a0b0c_81000aaa;
    hdr_valid = 1'b1;
    lkp_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    hdr_valid = 1'b0;
    lkp_valid = 1'b0;
    chk(out_hdr == 128'h01020304_0a020102_03040a0b_81000002, "R10 worked example",
        out_hdr, 128'h01020304_0a020102_03040a0b_81000002);
    chk(out_desc[31:16] == 16'd74, "R5 example frame length", out_desc[31:16], 16'd74);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;

    // R7: one-sided valids consume nothing
    hdr_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!hdr_ready, "R7 header alone not taken", hdr_ready, 0);
      @(negedge clk);
    end
    hdr_valid = 1'b0;
    lkp_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!lkp_ready, "R7 record alone not taken", lkp_ready, 0);
      @(negedge clk);
    end
    lkp_valid = 1'b0;
    chk(!out_valid, "R7 no packet from one side", out_valid, 0);

    // sweep destination byte under three MACs, with rotating stalls
    for (int m = 0; m < 3; m++) begin
      load_mac(macs[m]);
      for (int d = 0; d < 256; d++) begin
        seed = next_rnd(seed);
        rec = make_rec(seed, next_rnd(seed ^ 32'h5555_aaaa), d[7:0], seed[31:16]);
        seed = next_rnd(seed);
        run_pkt({seed, ~seed, seed ^ 32'h0f0f_0f0f, seed + 32'd7}, rec, d % 3, macs[m]);
      end
    end

    // R5: length wrap boundaries
    for (int i = 0; i < 5; i++) begin
      seed = next_rnd(seed);
      run_pkt({4{seed}}, make_rec(seed, ~seed, 8'hc3, lens[i]), 1, macs[2]);
    end

    // R11: only the unused record bytes differ, output must not
    rec = make_rec(32'h0bad_beef, 32'h7654_3210, 8'h11, 16'd300);
    run_pkt(128'h0, rec, 0, macs[2]);
    rec[79:64] = ~rec[79:64];
    run_pkt({4{32'hffff_ffff}}, rec, 0, macs[2]);

    // R9: streaming burst, one packet per cycle
    @(negedge clk);
    out_ready = 1'b1;
    hdr_valid = 1'b1;
    lkp_valid = 1'b1;
    for (int k = 0; k < 8; k++) begin
      lkp_rec = make_rec(32'h100 + k, 32'h2222_0000, 8'h40 + k[7:0], 16'd64);
      @(negedge clk);
      chk(out_valid && out_desc[95:64] == 32'h100 + k, "R9 one per cycle",
          out_desc[95:64], 32'h100 + k);
    end
    hdr_valid = 1'b0;
    lkp_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R9 burst drained", out_valid, 0);
    out_ready = 1'b0;

    // R2: MAC reload applies to the next packet
    load_mac(48'ha1b2_c3d4_e5f6);
    run_pkt(128'h0, make_rec(32'h77, 32'h88, 8'h99, 16'd1500), 2, 48'ha1b2_c3d4_e5f6);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule